// File: doc/BRIEF.md
# Spreading-Code Acquisition Search

This block finds coarse timing and code alignment in a direct-sequence spread-spectrum receiver. Each accepted sample cycle carries one chip-rate complex sample, with signed I and Q, for each of several pre-interpolated streams. The streams are evenly offset in fractional timing. The block correlates every stream against a programmable 31-chip spreading code at every possible code phase, all in parallel. The search uses no decisions, no pilots and no feedback, so every stream/phase pair is only a hypothesis that is scored independently.

A search period is 31 accepted samples, counted from reset or restart. At the end of each period the block compares all scores, using a metric that does not depend on carrier phase. It reports the winning stream index, the winning code phase and the peak score. It also raises a detect flag when the peak reaches a programmable threshold. Searching then continues at once with the next 31 samples. A small write port loads the code and the threshold. A synchronous restart input starts a fresh search at chip 0.

Top module: `pn_acq_search`

## Requirements
- R1: Write port: `cfg_addr`=0 loads the code from `cfg_wdata[30:0]`, where bit j is chip j. `cfg_addr`=1 loads the threshold from the low 12 bits. A code written during a period takes effect only from the next period's chip 0.
- R2: Accepted samples are numbered k=0..30 within a period. For stream s and phase p, with c(j)=+1 for code bit 1 and −1 for bit 0, the score is |Σ I_s[k]·c((k+p) mod 31)| + |Σ Q_s[k]·c((k+p) mod 31)|.
- R3: Full-scale inputs (−64 on I and Q) matched by the code give the exact score 3968, with no wrap.
- R4: `acq_valid` is a one-cycle pulse. It rises two clock edges after the edge that accepts chip 30.
- R5: `acq_stream` (3 bits), `acq_phase` (5 bits), `acq_peak` and `acq_detect` change only when `acq_valid` is high, and hold their values otherwise.
- R6: `acq_detect` is 1 exactly when the peak is greater than or equal to the threshold. Equality counts as a detection.
- R7: On equal scores, the lower stream index wins, and then the lower code phase.
- R8: Searching repeats without pause. Each new period starts from zero sums, even when periods follow back to back.
- R9: `restart` clears the sums and restarts at chip 0. A sample offered in the same cycle is ignored. A report still pending when restart arrives is dropped.
- R10: Cycles with `samp_valid` low do not advance the search and do not alter the sums.
- R11: After reset the outputs are zero, the code is all zeros and the threshold is all ones, so no peak can be detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Start a new search at chip 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = code, 1 = threshold |
| cfg_wdata | input | 31 | Configuration write data |
| samp_valid | input | 1 | Sample cycle valid for all streams |
| samp_i | input | 56 | In-phase samples, stream s in bits [7s+6:7s] |
| samp_q | input | 56 | Quadrature samples, same packing |
| acq_valid | output | 1 | Result pulse at end of period |
| acq_stream | output | 3 | Winning stream index |
| acq_phase | output | 5 | Winning code phase |
| acq_peak | output | 12 | Winning score |
| acq_detect | output | 1 | Peak reached the threshold |

## Verification
The first stimulus type plants the code on one stream at a chosen phase, in I and in negated Q, over noise. This tells whether the correlation uses the right chip-to-phase mapping and a metric that ignores the sign of the sums. All-zero and all-constant inputs make many scores equal, which exposes the stream-first, phase-second tie order. Full-scale negative inputs with an all-ones code probe accumulator width. A threshold set to exactly the expected peak, and then to one above it, separates ≥ from >. Gapped valid cycles, back-to-back periods, a code write in mid-period, and restarts placed before, on and just after the last chip check period framing and report dropping.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam logic CFG_SEL_CODE = 1'b0;
  localparam logic CFG_SEL_THR  = 1'b1;

  // signed width that holds chips * most negative sample magnitude
  function automatic int acc_bits(input int chips, input int sw);
    return $clog2(chips * (2 ** (sw - 1)) + 1) + 1;
  endfunction
endpackage

// File: rtl/acq_code_regs.sv
module acq_code_regs #(
  parameter int CHIPS = 31,
  parameter int MW    = 12,
  parameter int CFG_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CHIPS-1:0] code_q,
  output logic [MW-1:0]    thr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      thr_q  <= '1;
    end else if (we) begin
      if (addr == acq_pkg::CFG_SEL_CODE) code_q <= wdata[CHIPS-1:0];
      else                               thr_q  <= wdata[MW-1:0];
    end
  end

  generate
    if (CFG_W > MW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[CFG_W-1:MW];
    end
  endgenerate
endmodule

// File: rtl/acq_chip_seq.sv
module acq_chip_seq #(
  parameter int CHIPS = 31,
  parameter int PW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             samp_valid,
  input  logic [CHIPS-1:0] code,
  output logic [CHIPS-1:0] ref_bits,
  output logic             first_chip,
  output logic             period_done
);
  logic [PW-1:0]    chip_q;
  logic [CHIPS-1:0] rot_q;
  logic             last_chip;

  assign first_chip = (chip_q == '0);
  assign last_chip  = (chip_q == PW'(CHIPS - 1));
  // bit p of ref_bits is the code chip that phase p expects right now
  assign ref_bits   = first_chip ? code : rot_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      chip_q      <= '0;
      rot_q       <= '0;
      period_done <= 1'b0;
    end else begin
      period_done <= samp_valid && last_chip;
      if (samp_valid) begin
        chip_q <= last_chip ? '0 : chip_q + 1'b1;
        rot_q  <= {ref_bits[0], ref_bits[CHIPS-1:1]};
      end
    end
  end
endmodule

// File: rtl/acq_stream_corr.sv
module acq_stream_corr #(
  parameter int CHIPS = 31,
  parameter int SW    = 7,
  parameter int AW    = 12,
  parameter int PW    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 samp_valid,
  input  logic                 first_chip,
  input  logic                 capture,
  input  logic [CHIPS-1:0]     ref_bits,
  input  logic signed [SW-1:0] x_i,
  input  logic signed [SW-1:0] x_q,
  output logic [AW-1:0]        best_metric,
  output logic [PW-1:0]        best_phase
);
  logic signed [AW-1:0] xi_ext, xq_ext;
  logic [AW-1:0]        metric [CHIPS];

  assign xi_ext = {{(AW-SW){x_i[SW-1]}}, x_i};
  assign xq_ext = {{(AW-SW){x_q[SW-1]}}, x_q};

  generate
    for (genvar p = 0; p < CHIPS; p++) begin : g_ph
      logic signed [AW-1:0] acc_i_q, acc_q_q, base_i, base_q;
      logic [AW-1:0]        mag_i, mag_q;

      assign base_i = first_chip ? '0 : acc_i_q;
      assign base_q = first_chip ? '0 : acc_q_q;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          acc_i_q <= '0;
          acc_q_q <= '0;
        end else if (samp_valid) begin
          acc_i_q <= ref_bits[p] ? base_i + xi_ext : base_i - xi_ext;
          acc_q_q <= ref_bits[p] ? base_q + xq_ext : base_q - xq_ext;
        end
      end

      assign mag_i     = acc_i_q[AW-1] ? AW'(-acc_i_q) : AW'(acc_i_q);
      assign mag_q     = acc_q_q[AW-1] ? AW'(-acc_q_q) : AW'(acc_q_q);
      assign metric[p] = mag_i + mag_q;
    end
  endgenerate

  logic [AW-1:0] win_metric;
  logic [PW-1:0] win_phase;

  always_comb begin
    win_metric = metric[0];
    win_phase  = '0;
    for (int p = 1; p < CHIPS; p++) begin
      if (metric[p] > win_metric) begin
        win_metric = metric[p];
        win_phase  = PW'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_metric <= '0;
      best_phase  <= '0;
    end else if (capture) begin
      best_metric <= win_metric;
      best_phase  <= win_phase;
    end
  end
endmodule

// File: rtl/acq_peak_pick.sv
module acq_peak_pick #(
  parameter int NS  = 8,
  parameter int MW  = 12,
  parameter int PW  = 5,
  parameter int SIW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              in_valid,
  input  logic [NS*MW-1:0]  metrics,
  input  logic [NS*PW-1:0]  phases,
  input  logic [MW-1:0]     thr,
  output logic              acq_valid,
  output logic [SIW-1:0]    acq_stream,
  output logic [PW-1:0]     acq_phase,
  output logic [MW-1:0]     acq_peak,
  output logic              acq_detect
);
  logic [MW-1:0]  c_peak;
  logic [PW-1:0]  c_phase;
  logic [SIW-1:0] c_stream;

  always_comb begin
    c_peak   = metrics[0 +: MW];
    c_phase  = phases[0 +: PW];
    c_stream = '0;
    for (int s = 1; s < NS; s++) begin
      if (metrics[s*MW +: MW] > c_peak) begin
        c_peak   = metrics[s*MW +: MW];
        c_phase  = phases[s*PW +: PW];
        c_stream = SIW'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_valid  <= 1'b0;
      acq_stream <= '0;
      acq_phase  <= '0;
      acq_peak   <= '0;
      acq_detect <= 1'b0;
    end else begin
      acq_valid <= in_valid && !restart;
      if (in_valid && !restart) begin
        acq_stream <= c_stream;
        acq_phase  <= c_phase;
        acq_peak   <= c_peak;
        acq_detect <= (c_peak >= thr);
      end
    end
  end
endmodule

// File: rtl/pn_acq_search.sv
module pn_acq_search #(
  parameter int NS    = 8,
  parameter int CHIPS = 31,
  parameter int SW    = 7,
  localparam int AW    = acq_pkg::acc_bits(CHIPS, SW),
  localparam int MW    = AW,
  localparam int PW    = $clog2(CHIPS),
  localparam int SIW   = $clog2(NS),
  localparam int CFG_W = (CHIPS > MW) ? CHIPS : MW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             samp_valid,
  input  logic [NS*SW-1:0] samp_i,
  input  logic [NS*SW-1:0] samp_q,
  output logic             acq_valid,
  output logic [SIW-1:0]   acq_stream,
  output logic [PW-1:0]    acq_phase,
  output logic [MW-1:0]    acq_peak,
  output logic             acq_detect
);
  logic [CHIPS-1:0] code_q, ref_bits;
  logic [MW-1:0]    thr_q;
  logic             first_chip, period_done, done_d;
  logic [NS*MW-1:0] st_metric;
  logic [NS*PW-1:0] st_phase;

  acq_code_regs #(.CHIPS(CHIPS), .MW(MW), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .code_q(code_q), .thr_q(thr_q)
  );

  acq_chip_seq #(.CHIPS(CHIPS), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .restart(restart), .samp_valid(samp_valid),
    .code(code_q), .ref_bits(ref_bits), .first_chip(first_chip),
    .period_done(period_done)
  );

  generate
    for (genvar s = 0; s < NS; s++) begin : g_st
      acq_stream_corr #(.CHIPS(CHIPS), .SW(SW), .AW(AW), .PW(PW)) u_corr (
        .clk(clk), .rst(rst), .restart(restart), .samp_valid(samp_valid),
        .first_chip(first_chip), .capture(period_done), .ref_bits(ref_bits),
        .x_i(samp_i[s*SW +: SW]), .x_q(samp_q[s*SW +: SW]),
        .best_metric(st_metric[s*MW +: MW]), .best_phase(st_phase[s*PW +: PW])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) done_d <= 1'b0;
    else     done_d <= period_done && !restart;
  end

  acq_peak_pick #(.NS(NS), .MW(MW), .PW(PW), .SIW(SIW)) u_pick (
    .clk(clk), .rst(rst), .restart(restart), .in_valid(done_d),
    .metrics(st_metric), .phases(st_phase), .thr(thr_q),
    .acq_valid(acq_valid), .acq_stream(acq_stream), .acq_phase(acq_phase),
    .acq_peak(acq_peak), .acq_detect(acq_detect)
  );
endmodule

// File: rtl/pn_acq_search_chk.sv
module pn_acq_search_chk #(
  parameter int CHIPS = 31,
  parameter int SW    = 7,
  parameter int MW    = 12,
  parameter int PW    = 5,
  parameter int SIW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           restart,
  input logic           acq_valid,
  input logic [SIW-1:0] acq_stream,
  input logic [PW-1:0]  acq_phase,
  input logic [MW-1:0]  acq_peak,
  input logic           acq_detect,
  input logic [MW-1:0]  thr_q
);
  localparam int PEAK_MAX = 2 * CHIPS * (2 ** (SW - 1));

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    acq_valid |=> !acq_valid); // R4
  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (rst)
    restart |=> !acq_valid); // R9
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    acq_valid |-> (int'(acq_phase) < CHIPS)); // R2
  AST_DETECT_THR: assert property (@(posedge clk) disable iff (rst)
    acq_valid |-> (acq_detect == (acq_peak >= $past(thr_q)))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acq_valid |-> $stable({acq_stream, acq_phase, acq_peak, acq_detect})); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    acq_valid |-> (int'(acq_peak) <= PEAK_MAX)); // R3
endmodule

bind pn_acq_search pn_acq_search_chk #(
  .CHIPS(CHIPS), .SW(SW), .MW(MW), .PW(PW), .SIW(SIW)
) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .acq_valid(acq_valid),
  .acq_stream(acq_stream), .acq_phase(acq_phase), .acq_peak(acq_peak),
  .acq_detect(acq_detect), .thr_q(thr_q)
);

// File: tb/pn_acq_search_bench.sv
`timescale 1ns/1ps
module pn_acq_search_bench;
  localparam int NS = 8, CH = 31, SW = 7, MW = 12;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0;
  logic cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [30:0] cfg_wdata = '0;
  logic samp_valid = 1'b0;
  logic [NS*SW-1:0] samp_i = '0, samp_q = '0;
  logic acq_valid, acq_detect;
  logic [2:0] acq_stream;
  logic [4:0] acq_phase;
  logic [MW-1:0] acq_peak;

  pn_acq_search u_pn_acq_search (.*);

  always #2.5 clk = ~clk;

  typedef struct {int stream; int phase; int peak; bit detect; int due; string req;} exp_t;
  exp_t exp_q[$];
  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [30:0] code_b = '0;
  int thr_b = 4095;
  int si [NS][CH];
  int sq [NS][CH];
  int last_st = 0, last_ph = 0, last_pk = 0;
  bit last_det = 0, done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected reports, checks hold between reports (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (acq_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected report", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(acq_stream) == e.stream, e.req, "stream", int'(acq_stream), e.stream);
          check(int'(acq_phase) == e.phase, e.req, "phase", int'(acq_phase), e.phase);
          check(int'(acq_peak) == e.peak, e.req, "peak", int'(acq_peak), e.peak);
          check(acq_detect == e.detect, e.req, "detect", int'(acq_detect), int'(e.detect));
          check(cyc == e.due, "R4", "report cycle", cyc, e.due);
        end
        last_st = acq_stream; last_ph = acq_phase; last_pk = acq_peak; last_det = acq_detect;
      end else begin
        check(int'(acq_peak) == last_pk && int'(acq_stream) == last_st &&
              int'(acq_phase) == last_ph && acq_detect == last_det,
              "R5", "outputs held", int'(acq_peak), last_pk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WD", "watchdog expired", cyc, 0);
    summary();
  end

  function automatic int clamp(int v);
    return (v > 63) ? 63 : ((v < -64) ? -64 : v);
  endfunction

  function automatic int cbit(logic [30:0] c, int j);
    return c[j % CH] ? 1 : -1;
  endfunction

  function automatic int noise(int a);
    return int'($urandom_range(2 * a, 0)) - a;
  endfunction

  task automatic fill_noise(int a);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < CH; k++) begin
        si[s][k] = noise(a); sq[s][k] = noise(a);
      end
  endtask

  task automatic fill_const(int vi, int vq);
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < CH; k++) begin
        si[s][k] = vi; sq[s][k] = vq;
      end
  endtask

  task automatic plant(int s, int ph, int amp, logic [30:0] c);
    for (int k = 0; k < CH; k++) begin
      si[s][k] = clamp(si[s][k] + amp * cbit(c, k + ph));
      sq[s][k] = clamp(sq[s][k] - amp * cbit(c, k + ph));
    end
  endtask

  // reference model straight from R2, R6, R7
  function automatic exp_t model(logic [30:0] c, int thr);
    exp_t e;
    e.peak = -1; e.stream = 0; e.phase = 0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < CH; p++) begin
        int a, b, m;
        a = 0; b = 0;
        for (int k = 0; k < CH; k++) begin
          a += si[s][k] * cbit(c, k + p);
          b += sq[s][k] * cbit(c, k + p);
        end
        m = (a < 0 ? -a : a) + (b < 0 ? -b : b);
        if (m > e.peak) begin e.peak = m; e.stream = s; e.phase = p; end
      end
    e.detect = (e.peak >= thr);
    return e;
  endfunction

  task automatic wr_cfg(bit a, logic [30:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a) thr_b = int'(d[MW-1:0]); else code_b = d;
  endtask

  task automatic drive_chips(int n, int gapm, bit mid_wr, logic [30:0] mid_code);
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < (gapm ? (k % 3) : 0); g++) begin
        samp_valid = 0; samp_i = {NS*SW{1'b1}}; samp_q = {NS*SW{1'b1}};
        @(negedge clk);
      end
      for (int s = 0; s < NS; s++) begin
        samp_i[s*SW +: SW] = SW'(si[s][k]);
        samp_q[s*SW +: SW] = SW'(sq[s][k]);
      end
      samp_valid = 1;
      if (mid_wr && k == 10) begin cfg_we = 1; cfg_addr = 0; cfg_wdata = mid_code; end
      @(negedge clk);
      cfg_we = 0;
    end
    samp_valid = 0;
  endtask

  task automatic period(string req, int gapm, bit mid_wr = 0, logic [30:0] mid_code = '0);
    exp_t e;
    e = model(code_b, thr_b);
    e.req = req;
    drive_chips(CH, gapm, mid_wr, mid_code);
    e.due = cyc + 2;
    exp_q.push_back(e);
    if (mid_wr) code_b = mid_code;
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R9", "pending reports", exp_q.size(), 0);
  endtask

  initial begin
    logic [30:0] mseq, alt;
    logic [4:0] lf;
    exp_t pe;
    lf = 5'b00001;
    for (int j = 0; j < CH; j++) begin
      mseq[j] = lf[0];
      lf = {lf[0] ^ lf[2], lf[4:1]};
    end
    alt = {mseq[15:0], mseq[30:16]} ^ 31'h2AAAAAAA;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    check(acq_valid == 0, "R11", "valid after reset", int'(acq_valid), 0);
    check(acq_peak == 0 && acq_stream == 0 && acq_phase == 0, "R11", "outputs after reset", int'(acq_peak), 0);
    check(acq_detect == 0, "R11", "detect after reset", int'(acq_detect), 0);

    // R11: default code all zeros, threshold all ones -> no detection
    fill_noise(6); plant(4, 7, 40, code_b);
    period("R11", 0);
    drain();

    // R1, R2, R6: programmed m-sequence, planted stream 5 phase 13
    wr_cfg(1, 31'd600);
    wr_cfg(0, mseq);
    fill_noise(10); plant(5, 13, 40, code_b);
    period("R2", 0);
    drain();

    // R10: gaps between accepted samples, planted stream 2 phase 30
    fill_noise(10); plant(2, 30, 35, code_b);
    period("R10", 1);
    drain();

    // R8: back-to-back periods with different winners
    fill_noise(8); plant(1, 0, 30, code_b);
    period("R8", 0);
    fill_noise(8); plant(7, 22, 30, code_b);
    period("R8", 0);
    drain();

    // R7: all-zero input, every score ties at 0
    fill_const(0, 0);
    period("R7", 0);
    drain();

    // R3, R7: all-ones code, full-scale negative input -> 3968 everywhere
    wr_cfg(0, 31'h7FFFFFFF);
    fill_const(-64, -64);
    period("R3", 0);
    drain();

    // R7: streams 3 and 6 identical, the rest zero -> stream 3 wins
    fill_const(0, 0);
    for (int k = 0; k < CH; k++) begin si[3][k] = 20; si[6][k] = 20; end
    period("R7", 0);
    drain();

    // R6: threshold exactly at the peak, then one above
    wr_cfg(0, mseq);
    fill_noise(10); plant(6, 4, 25, code_b);
    pe = model(code_b, 0);
    wr_cfg(1, 31'(pe.peak));
    period("R6", 0);
    drain();
    wr_cfg(1, 31'(pe.peak + 1));
    period("R6", 0);
    drain();
    wr_cfg(1, 31'd600);

    // R1: code written mid-period applies from the next period
    fill_noise(8); plant(0, 9, 35, code_b);
    period("R1", 0, 1, alt);
    fill_noise(8); plant(3, 17, 35, code_b);
    period("R1", 0);
    drain();

    // R9: restart part-way through a period, then a full period
    fill_noise(8); plant(2, 5, 35, code_b);
    drive_chips(10, 0, 0, '0);
    restart = 1; @(negedge clk); restart = 0;
    period("R9", 0);
    drain();

    // R9: restart the cycle after chip 30 drops the report
    drive_chips(CH, 0, 0, '0);
    restart = 1; @(negedge clk); restart = 0;
    drain();

    // R9: sample offered with restart is ignored
    for (int s = 0; s < NS; s++) begin samp_i[s*SW +: SW] = 7'h3F; samp_q[s*SW +: SW] = 7'h40; end
    samp_valid = 1; restart = 1; @(negedge clk); restart = 0; samp_valid = 0;
    fill_noise(8); plant(4, 26, 35, code_b);
    period("R9", 0);
    drain();

    summary();
  end
endmodule